// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Write Sequencer

This block is a bus master for a narrow external bus on which the address and the data share the same pins. A single write request becomes a fixed sequence on that bus. The address goes out first, framed by an address latch enable pulse. After one address-hold cycle the pins switch to the data word. An active-low write strobe then frames the data. A hold window and a recovery window end the cycle. Every phase is counted in whole cycles of the block clock.

Three configuration inputs shape the cycle. A 5-bit duration field `D` sets the strobe length. A hold bit adds one data-hold cycle (`H`). A flash bit moves a fixed constant `F` of cycles (seven by default) out of the strobe and into the recovery window. A polarity bit inverts the latch enable; out of reset it is active high. The block samples the request inputs and all configuration inputs only on the clock edge that accepts a request. After that it ignores them until it is idle again.

Top module: `mxw_write_seq`

## Requirements
- R1: While reset is held and right after it is released: latch enable at 0, write strobe high, bus output enable low, ready high.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. For the next 2 cycles the latch enable is active, `bus_oe` is high, `bus_out` carries the accepted address and `wr_n` is high.
- R3: In the cycle after the latch enable ends, the address is still driven. In the cycle after that the data word is driven with `wr_n` still high, so `wr_n` falls two cycles after the latch enable deasserts.
- R4: `wr_n` stays low for `D - F` consecutive cycles. `F` equals 7 when `cfg_flash` is 1 and 0 otherwise.
- R5: When `D <= F` (this includes `D = 0`), the strobe is low for exactly one cycle.
- R6: The data word is driven in the cycle before `wr_n` falls, in every strobe-low cycle, and in `H` cycles after `wr_n` rises. `H` is 1 when `cfg_hold` is 1 and 0 otherwise.
- R7: After the hold window there are `F` recovery cycles with `bus_oe` low, `wr_n` high and `req_ready` low. Only after them does the block return to idle.
- R8: `cfg_ale_low` is sampled at acceptance. When it is 1, the latch enable is driven inverted: 0 while active and 1 otherwise, idle included, until a later acceptance samples 0.
- R9: `req_ready` is low from the cycle after acceptance until recovery ends. While it is low, any change on `req_valid`, the address, the data or the configuration has no effect on the running cycle. A request held high is accepted on the first edge where the block is idle.
- R10: In idle, `bus_oe` is low and `wr_n` is high. `bus_oe` is high exactly while the address or the data is being driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; every phase length counts its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request |
| req_ready | output | 1 | High when idle and able to accept |
| req_addr | input | 16 | Address to place on the bus |
| req_data | input | 16 | Data word to write |
| cfg_dur | input | 5 | Data-cycle duration D |
| cfg_hold | input | 1 | Adds one data-hold cycle after the strobe |
| cfg_flash | input | 1 | Moves F cycles from the strobe into recovery |
| cfg_ale_low | input | 1 | Selects an active-low latch enable |
| bus_out | output | 16 | Value driven on the shared pins |
| bus_oe | output | 1 | Output enable for the shared pins |
| ale | output | 1 | Address latch enable |
| wr_n | output | 1 | Active-low write strobe |

## Verification
The hardest case to reach from the ports is a change of request and configuration inputs in the middle of a running cycle. It only matters when `req_valid` is still high on the very edge where the block turns idle. The stimulus keeps `req_valid` high and scrambles the address, the data and every configuration field on each busy cycle. The reference model only samples those inputs when it predicts an idle edge, so any early or late sampling shows up as a mismatch in the next cycle's timing. Flash mode with `D` of 7 or less, and `D = 0`, cover the clamp. Back-to-back requests cover the recovery edge.

// File: rtl/mxw_pkg.sv
package mxw_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_ADDR   = 3'd1,
    PH_AHOLD  = 3'd2,
    PH_SETUP  = 3'd3,
    PH_STROBE = 3'd4,
    PH_HOLD   = 3'd5,
    PH_RECOV  = 3'd6
  } phase_e;

endpackage

// File: rtl/mxw_cfg_latch.sv
module mxw_cfg_latch #(
  parameter int BUS_W     = 16,
  parameter int DUR_W     = 5,
  parameter int FLASH_EXT = 7,
  parameter int CNT_W     = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [BUS_W-1:0] in_addr,
  input  logic [BUS_W-1:0] in_data,
  input  logic [DUR_W-1:0] in_dur,
  input  logic             in_hold,
  input  logic             in_flash,
  input  logic             in_ale_low,
  output logic [BUS_W-1:0] addr_q,
  output logic [BUS_W-1:0] data_q,
  output logic [CNT_W-1:0] strobe_len,
  output logic [CNT_W-1:0] hold_len,
  output logic [CNT_W-1:0] recov_len,
  output logic             ale_low_q
);

  logic [CNT_W-1:0] dur_ext;
  logic [CNT_W-1:0] flash_cyc;
  logic [CNT_W-1:0] strobe_calc;

  logic [BUS_W-1:0] addr_n, data_n;
  logic [CNT_W-1:0] strobe_n, hold_n, recov_n;
  logic             ale_low_n;

  // Derived phase lengths, clamped so the strobe is never shorter than one cycle.
  always_comb begin
    dur_ext     = CNT_W'(in_dur);
    flash_cyc   = in_flash ? CNT_W'(FLASH_EXT) : '0;
    strobe_calc = (dur_ext > flash_cyc) ? (dur_ext - flash_cyc) : CNT_W'(1);
  end

  always_comb begin
    addr_n    = addr_q;
    data_n    = data_q;
    strobe_n  = strobe_len;
    hold_n    = hold_len;
    recov_n   = recov_len;
    ale_low_n = ale_low_q;
    if (accept) begin
      addr_n    = in_addr;
      data_n    = in_data;
      strobe_n  = strobe_calc;
      hold_n    = in_hold ? CNT_W'(1) : '0;
      recov_n   = flash_cyc;
      ale_low_n = in_ale_low;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q     <= '0;
      data_q     <= '0;
      strobe_len <= CNT_W'(1);
      hold_len   <= '0;
      recov_len  <= '0;
      ale_low_q  <= 1'b0;
    end else begin
      addr_q     <= addr_n;
      data_q     <= data_n;
      strobe_len <= strobe_n;
      hold_len   <= hold_n;
      recov_len  <= recov_n;
      ale_low_q  <= ale_low_n;
    end
  end

endmodule

// File: rtl/mxw_phase_fsm.sv
module mxw_phase_fsm
  import mxw_pkg::*;
#(
  parameter int CNT_W   = 6,
  parameter int ALE_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [CNT_W-1:0] strobe_len,
  input  logic [CNT_W-1:0] hold_len,
  input  logic [CNT_W-1:0] recov_len,
  output phase_e           phase,
  output logic             ready,
  output logic             accept
);

  phase_e           phase_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic             last;

  assign ready  = (phase == PH_IDLE);
  assign accept = req && ready;
  assign last   = (cnt == '0);

  always_comb begin
    phase_n = phase;
    cnt_n   = cnt;
    unique case (phase)
      PH_IDLE: begin
        if (req) begin
          phase_n = PH_ADDR;
          cnt_n   = CNT_W'(ALE_CYC - 1);
        end
      end
      PH_ADDR: begin
        if (last) phase_n = PH_AHOLD;
        else      cnt_n   = cnt - 1'b1;
      end
      PH_AHOLD: begin
        phase_n = PH_SETUP;
        cnt_n   = '0;
      end
      PH_SETUP: begin
        phase_n = PH_STROBE;
        cnt_n   = strobe_len - 1'b1;
      end
      PH_STROBE: begin
        if (!last) begin
          cnt_n = cnt - 1'b1;
        end else if (hold_len != '0) begin
          phase_n = PH_HOLD;
          cnt_n   = hold_len - 1'b1;
        end else if (recov_len != '0) begin
          phase_n = PH_RECOV;
          cnt_n   = recov_len - 1'b1;
        end else begin
          phase_n = PH_IDLE;
        end
      end
      PH_HOLD: begin
        if (!last) begin
          cnt_n = cnt - 1'b1;
        end else if (recov_len != '0) begin
          phase_n = PH_RECOV;
          cnt_n   = recov_len - 1'b1;
        end else begin
          phase_n = PH_IDLE;
        end
      end
      PH_RECOV: begin
        if (last) phase_n = PH_IDLE;
        else      cnt_n   = cnt - 1'b1;
      end
      default: begin
        phase_n = PH_IDLE;
        cnt_n   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      phase <= phase_n;
      cnt   <= cnt_n;
    end
  end

  // Checker counters: run lengths of the strobe and recovery windows.
  logic [CNT_W-1:0] low_run, rec_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run <= '0;
      rec_run <= '0;
    end else begin
      if (phase == PH_STROBE)     low_run <= low_run + 1'b1;
      else if (phase == PH_SETUP) low_run <= '0;
      if (phase == PH_RECOV)      rec_run <= rec_run + 1'b1;
      else if (phase == PH_SETUP) rec_run <= '0;
    end
  end

  assert_strobe_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_STROBE && $past(phase) == PH_STROBE) |-> (low_run == strobe_len));

  assert_recov_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_RECOV && $past(phase) == PH_RECOV) |-> (rec_run == recov_len));

  assert_entry_from_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE && phase != PH_ADDR) |=> (phase != PH_ADDR));

endmodule

// File: rtl/mxw_bus_drive.sv
module mxw_bus_drive
  import mxw_pkg::*;
#(
  parameter int BUS_W = 16
) (
  input  phase_e           phase,
  input  logic [BUS_W-1:0] addr_q,
  input  logic [BUS_W-1:0] data_q,
  input  logic             ale_low_q,
  output logic [BUS_W-1:0] bus_out,
  output logic             bus_oe,
  output logic             ale,
  output logic             ale_act,
  output logic             wr_n
);

  logic drive_addr, drive_data;

  always_comb begin
    drive_addr = (phase == PH_ADDR) || (phase == PH_AHOLD);
    drive_data = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
    ale_act    = (phase == PH_ADDR);
    wr_n       = (phase != PH_STROBE);
    bus_oe     = drive_addr || drive_data;
    if (drive_addr)      bus_out = addr_q;
    else if (drive_data) bus_out = data_q;
    else                 bus_out = '0;
    ale = ale_act ^ ale_low_q;
  end

endmodule

// File: rtl/mxw_write_seq.sv
module mxw_write_seq
  import mxw_pkg::*;
#(
  parameter int BUS_W     = 16,
  parameter int DUR_W     = 5,
  parameter int FLASH_EXT = 7,
  parameter int ALE_CYC   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [BUS_W-1:0] req_addr,
  input  logic [BUS_W-1:0] req_data,
  input  logic [DUR_W-1:0] cfg_dur,
  input  logic             cfg_hold,
  input  logic             cfg_flash,
  input  logic             cfg_ale_low,
  output logic [BUS_W-1:0] bus_out,
  output logic             bus_oe,
  output logic             ale,
  output logic             wr_n
);

  localparam int CNT_W = DUR_W + 1;

  phase_e           phase;
  logic             accept;
  logic [BUS_W-1:0] addr_q, data_q;
  logic [CNT_W-1:0] strobe_len, hold_len, recov_len;
  logic             ale_low_q;
  logic             ale_act;

  mxw_cfg_latch #(
    .BUS_W(BUS_W), .DUR_W(DUR_W), .FLASH_EXT(FLASH_EXT), .CNT_W(CNT_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .accept(accept),
    .in_addr(req_addr), .in_data(req_data), .in_dur(cfg_dur),
    .in_hold(cfg_hold), .in_flash(cfg_flash), .in_ale_low(cfg_ale_low),
    .addr_q(addr_q), .data_q(data_q),
    .strobe_len(strobe_len), .hold_len(hold_len), .recov_len(recov_len),
    .ale_low_q(ale_low_q)
  );

  mxw_phase_fsm #(
    .CNT_W(CNT_W), .ALE_CYC(ALE_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .req(req_valid),
    .strobe_len(strobe_len), .hold_len(hold_len), .recov_len(recov_len),
    .phase(phase), .ready(req_ready), .accept(accept)
  );

  mxw_bus_drive #(
    .BUS_W(BUS_W)
  ) u_drv (
    .phase(phase), .addr_q(addr_q), .data_q(data_q), .ale_low_q(ale_low_q),
    .bus_out(bus_out), .bus_oe(bus_oe), .ale(ale), .ale_act(ale_act), .wr_n(wr_n)
  );

  assert_ale_drives_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ale_act |-> (bus_oe && wr_n && !req_ready));

  assert_wr_after_ale_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale_act) |=> (wr_n && bus_oe) ##1 !wr_n);

  assert_data_on_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> (bus_oe && !req_ready && !ale_act));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (wr_n && !bus_oe));

endmodule

// File: tb/mxw_write_seq_tb.sv
module mxw_write_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_addr = '0;
  logic [15:0] req_data = '0;
  logic [4:0]  cfg_dur = '0;
  logic        cfg_hold = 1'b0;
  logic        cfg_flash = 1'b0;
  logic        cfg_ale_low = 1'b0;
  logic [15:0] bus_out;
  logic        bus_oe;
  logic        ale;
  logic        wr_n;

  always #5 clk = ~clk;

  mxw_write_seq u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data),
    .cfg_dur(cfg_dur), .cfg_hold(cfg_hold), .cfg_flash(cfg_flash),
    .cfg_ale_low(cfg_ale_low),
    .bus_out(bus_out), .bus_oe(bus_oe), .ale(ale), .wr_n(wr_n)
  );

  typedef struct {
    bit          ale_a;
    bit          wr_n;
    bit          oe;
    logic [15:0] bus;
    bit          rdy;
    string       tag;
  } exp_t;

  exp_t  q[$];
  bit    prev_idle = 1'b0;
  bit    alow_m = 1'b0;
  bit    accepted = 1'b0;
  int    checks = 0;
  int    fails = 0;
  string ctx = "";
  bit    done = 1'b0;

  function automatic exp_t mk(bit a, bit w, bit o, logic [15:0] b, bit r, string t);
    exp_t e;
    e.ale_a = a; e.wr_n = w; e.oe = o; e.bus = b; e.rdy = r; e.tag = t;
    return e;
  endfunction

  // Reference model: expected per-cycle outputs of one accepted write.
  function automatic void push_txn();
    int f, w, h;
    f = cfg_flash ? 7 : 0;
    w = (int'(cfg_dur) > f) ? int'(cfg_dur) - f : 1;
    h = cfg_hold ? 1 : 0;
    alow_m = cfg_ale_low;
    for (int i = 0; i < 2; i++) q.push_back(mk(1, 1, 1, req_addr, 0, "R2"));
    q.push_back(mk(0, 1, 1, req_addr, 0, "R3"));
    q.push_back(mk(0, 1, 1, req_data, 0, "R6"));
    for (int i = 0; i < w; i++)
      q.push_back(mk(0, 0, 1, req_data, 0, (int'(cfg_dur) <= f) ? "R5" : "R4"));
    for (int i = 0; i < h; i++) q.push_back(mk(0, 1, 1, req_data, 0, "R6"));
    for (int i = 0; i < f; i++) q.push_back(mk(0, 1, 0, 16'h0, 0, "R7"));
    accepted = 1'b1;
  endfunction

  task automatic step();
    exp_t e;
    bit   ok;
    bit   exp_ale;
    if (prev_idle && req_valid) push_txn();
    @(negedge clk);
    if (q.size() > 0) e = q.pop_front();
    else              e = mk(0, 1, 0, 16'h0, 1, alow_m ? "R8" : "R10");
    exp_ale = e.ale_a ^ alow_m;
    ok = (ale == exp_ale) && (wr_n == e.wr_n) && (bus_oe == e.oe) &&
         (req_ready == e.rdy) && (!e.oe || bus_out == e.bus);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got ale=%b wr_n=%b oe=%b rdy=%b bus=%h, expected ale=%b wr_n=%b oe=%b rdy=%b bus=%h",
               e.tag, ctx, ale, wr_n, bus_oe, req_ready, bus_out,
               exp_ale, e.wr_n, e.oe, e.rdy, e.bus);
    end
    prev_idle = e.rdy;
  endtask

  task automatic txn(logic [15:0] a, logic [15:0] d, logic [4:0] dur,
                     bit h, bit fl, bit al, bit scramble, bit keep_req);
    req_addr = a; req_data = d; cfg_dur = dur;
    cfg_hold = h; cfg_flash = fl; cfg_ale_low = al;
    req_valid = 1'b1;
    accepted = 1'b0;
    for (int n = 0; n < 8 && !accepted; n++) step();
    if (!keep_req && !scramble) req_valid = 1'b0;
    while (q.size() > 0) begin
      if (scramble) begin
        req_valid   = 1'b1;
        req_addr    = 16'($urandom);
        req_data    = 16'($urandom);
        cfg_dur     = 5'($urandom);
        cfg_hold    = 1'($urandom);
        cfg_flash   = 1'($urandom);
        cfg_ale_low = 1'($urandom);
      end
      step();
    end
    if (!keep_req) req_valid = 1'b0;
  endtask

  task automatic idle_cycles(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    // R1: outputs during reset
    repeat (3) @(negedge clk);
    checks++;
    if (!(ale == 1'b0 && wr_n == 1'b1 && bus_oe == 1'b0 && req_ready == 1'b1)) begin
      fails++;
      $display("FAIL R1 reset: got ale=%b wr_n=%b oe=%b rdy=%b, expected ale=0 wr_n=1 oe=0 rdy=1",
               ale, wr_n, bus_oe, req_ready);
    end
    rst_n = 1'b1;
    prev_idle = 1'b1;
    ctx = "R1";
    idle_cycles(2);

    ctx = "plain";
    txn(16'h1234, 16'hABCD, 5'd5, 0, 0, 0, 0, 0);
    idle_cycles(2);
    ctx = "hold";
    txn(16'h0F0F, 16'hF0F0, 5'd10, 1, 0, 0, 0, 0);
    idle_cycles(1);
    ctx = "flash";
    txn(16'h5555, 16'hAAAA, 5'd12, 1, 1, 0, 0, 0);
    idle_cycles(1);
    ctx = "flash_clamp";
    txn(16'h0001, 16'h8000, 5'd3, 0, 1, 0, 0, 0);
    ctx = "zero_dur";
    txn(16'hBEEF, 16'hCAFE, 5'd0, 0, 0, 0, 0, 0);
    ctx = "max_dur";
    txn(16'hFFFF, 16'h0000, 5'd31, 1, 0, 0, 0, 0);
    ctx = "ale_low";
    txn(16'h2468, 16'h1357, 5'd4, 1, 0, 1, 0, 0);
    idle_cycles(3);
    ctx = "R9_scramble";
    txn(16'h7777, 16'h3333, 5'd9, 1, 1, 0, 1, 0);
    idle_cycles(2);
    ctx = "R9_back_to_back";
    txn(16'h1111, 16'h2222, 5'd2, 0, 0, 0, 0, 1);
    txn(16'h3333, 16'h4444, 5'd8, 1, 1, 1, 0, 1);
    txn(16'h5555, 16'h6666, 5'd7, 0, 1, 0, 0, 0);
    idle_cycles(3);

    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got no completion, expected completion within 100000 cycles");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule